// File: doc/BRIEF.md
# Oversampling Serial Receiver with Error-Tagged FIFO

This block recovers characters from an asynchronous serial line. It samples the line with an enable that pulses sixteen times per bit period, checks each start bit at the middle of the bit, and assembles a character in one of five frame formats. Each finished character is written into a 16-entry first-in first-out store. Each entry carries its own parity-error and framing-error flags, so the consumer sees each error on the exact character it belongs to.

The consumer pops entries through a read strobe and sees the oldest entry on a show-ahead output. A status vector reports not-empty, the error flags of the head entry, overrun, idle timeout and half-full. An interrupt line is raised when any status bit is set whose enable bit is also set. A loopback select feeds the local transmitter output into the receiver in place of the external pin. A flush strobe empties the store. Baud-rate generation and the register bus sit outside the block.

Top module: `srx_core`

## Requirements
- R1: `cfg_mode` selects the frame, with data sent least significant bit first after one low start bit: 3'b001 gives 8 data bits, 3'b011 gives 7 data bits plus parity, 3'b111 gives 8 data bits plus parity, and 3'b100 or 3'b101 give 9 data bits. Any other code behaves as 3'b001. The read word holds the data in bits 7:0 (bits 8:0 for the 9-bit codes), with unused data bits at zero.
- R2: In the two parity codes, bit 8 of the read word is set when the received parity disagrees with even parity (`cfg_odd`=0) or odd parity (`cfg_odd`=1). In the other codes it is never set as an error flag.
- R3: Bit 9 of the read word is set when the first stop bit samples low. A line held low for a whole frame in code 3'b001 yields the word 10'h200 (break).
- R4: A start bit is accepted only if the line is still low 8 ticks after the falling edge. A low pulse shorter than half a bit produces no character.
- R5: Characters leave the store in arrival order. The store holds 16 entries. Status bit 0 is set while it holds at least one entry, and status bit 8 is set while it holds 8 or more.
- R6: A character that completes while the store is full is dropped and sets status bit 5. Bit 5 clears on the next read of a non-empty store.
- R7: Status bit 7 sets once the store holds data and the receiver has been idle for `cfg_tmo` character periods of 160 ticks each. It clears when a character arrives, on a read, or when the store is empty. A `cfg_tmo` of 0 disables it.
- R8: `irq` is high exactly when some bit of `status` and the same bit of `cfg_irq_en` are both set.
- R9: When `cfg_loop` is 1 the receiver listens to `txd_loop` and ignores `rxd_pin`.
- R10: When `cfg_rx_en` is 0 no character is accepted.
- R11: A one-cycle `rx_flush` empties the store and clears overrun and timeout.
- R12: Status bits 3 and 4 show the parity-error (only in parity codes) and framing-error flags of the entry at the head of the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Oversampling enable, 16 pulses per bit |
| rxd_pin | input | 1 | External serial input, idle high |
| txd_loop | input | 1 | Local transmitter output for loopback |
| cfg_loop | input | 1 | 1 selects txd_loop as the line |
| cfg_rx_en | input | 1 | Receiver enable |
| cfg_mode | input | 3 | Frame format code |
| cfg_odd | input | 1 | 1 selects odd parity |
| cfg_tmo | input | 8 | Idle timeout in character periods, 0 disables |
| cfg_irq_en | input | 9 | Interrupt enable per status bit |
| rx_flush | input | 1 | Flush strobe for the store |
| rd_en | input | 1 | Pop the head entry |
| rd_data | output | 10 | Head entry: FE bit 9, PE bit 8, data below |
| status | output | 9 | Status vector, see R5 to R7 and R12 |
| irq | output | 1 | Masked interrupt |

## Verification
A sampler that slips by a tick or shifts in the wrong order shows up in the first character read back, within one frame time (about 160 cycles). A miscounted store occupancy shows on the not-empty and half-full bits as soon as the eighth or sixteenth entry arrives, and in the order of the words read back. A wrong overrun or timeout state only shows after a full store or after hundreds of idle ticks, so the bench waits out those windows and samples on both sides of the expected edge.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic [2:0] {
        FMT_8  = 3'b001,
        FMT_7P = 3'b011,
        FMT_9  = 3'b100,
        FMT_8W = 3'b101,
        FMT_8P = 3'b111
    } fmt_e;

    typedef struct packed {
        logic       fe;
        logic       hi;
        logic [7:0] lo;
    } rx_word_t;

    localparam int STAT_W = 9;
    localparam int ST_NE  = 0;
    localparam int ST_PE  = 3;
    localparam int ST_FE  = 4;
    localparam int ST_OV  = 5;
    localparam int ST_TO  = 7;
    localparam int ST_HF  = 8;
    localparam int SH_W   = 9;

    function automatic logic [3:0] frame_len(input logic [2:0] mode);
        case (mode)
            FMT_9, FMT_8W, FMT_8P: frame_len = 4'd9;
            default:               frame_len = 4'd8;
        endcase
    endfunction

    function automatic rx_word_t build_word(input logic [2:0] mode, input logic odd,
                                            input logic [SH_W-1:0] sh, input logic fe);
        logic [SH_W-1:0] raw;
        rx_word_t w;
        raw = sh >> (SH_W - int'(frame_len(mode)));
        w.fe = fe;
        case (mode)
            FMT_9, FMT_8W: begin
                w.hi = raw[8];
                w.lo = raw[7:0];
            end
            FMT_7P: begin
                w.hi = (^raw[7:0]) ^ odd;
                w.lo = {1'b0, raw[6:0]};
            end
            FMT_8P: begin
                w.hi = (^raw[8:0]) ^ odd;
                w.lo = raw[7:0];
            end
            default: begin
                w.hi = 1'b0;
                w.lo = raw[7:0];
            end
        endcase
        return w;
    endfunction

endpackage

// File: rtl/srx_sampler.sv
module srx_sampler
    import srx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       en,
    input  logic       line,
    input  logic [2:0] mode,
    input  logic       odd,
    output logic       done,
    output rx_word_t   word,
    output logic       busy
);
    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] MID_C  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST_C = CW'(OSR - 1);

    typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} st_e;

    st_e             st;
    logic [CW-1:0]   cnt;
    logic [3:0]      bidx;
    logic [SH_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= S_IDLE;
            cnt  <= '0;
            bidx <= '0;
            sh   <= '0;
            done <= 1'b0;
            word <= '0;
        end else begin
            done <= 1'b0;
            if (!en) begin
                st <= S_IDLE;
            end else if (tick) begin
                case (st)
                    S_IDLE: if (!line) begin
                        st  <= S_START;
                        cnt <= '0;
                    end
                    S_START: if (cnt == MID_C) begin
                        cnt  <= '0;
                        bidx <= '0;
                        st   <= line ? S_IDLE : S_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                    S_DATA: if (cnt == LAST_C) begin
                        cnt  <= '0;
                        sh   <= {line, sh[SH_W-1:1]};
                        bidx <= bidx + 1'b1;
                        if (bidx == frame_len(mode) - 4'd1) st <= S_STOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                    default: if (cnt == LAST_C) begin
                        st   <= S_IDLE;
                        done <= 1'b1;
                        word <= build_word(mode, odd, sh, !line);
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                endcase
            end
        end
    end

    assign busy = (st != S_IDLE);
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 10
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       flush,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CNTW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign do_push = push && (count != CNTW'(DEPTH));
    assign do_pop  = pop && (count != '0);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wp] <= din;
    end

    assign dout = mem[rp];
endmodule

// File: rtl/srx_idle_timer.sv
module srx_idle_timer #(
    parameter int OSR       = 16,
    parameter int CHAR_BITS = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       clr,
    input  logic       run,
    input  logic [7:0] limit,
    output logic       expired
);
    localparam int CT = OSR * CHAR_BITS;
    localparam int TW = $clog2(CT);

    logic [TW-1:0] tcnt;
    logic [7:0]    ccnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            tcnt <= '0;
            ccnt <= '0;
        end else if (run && tick) begin
            if (tcnt == TW'(CT - 1)) begin
                tcnt <= '0;
                if (ccnt != 8'hFF) ccnt <= ccnt + 1'b1;
            end else begin
                tcnt <= tcnt + 1'b1;
            end
        end
    end

    assign expired = (limit != 8'd0) && (ccnt >= limit);
endmodule

// File: rtl/srx_core.sv
module srx_core
    import srx_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick16,
    input  logic              rxd_pin,
    input  logic              txd_loop,
    input  logic              cfg_loop,
    input  logic              cfg_rx_en,
    input  logic [2:0]        cfg_mode,
    input  logic              cfg_odd,
    input  logic [7:0]        cfg_tmo,
    input  logic [STAT_W-1:0] cfg_irq_en,
    input  logic              rx_flush,
    input  logic              rd_en,
    output logic [9:0]        rd_data,
    output logic [STAT_W-1:0] status,
    output logic              irq
);
    localparam int CNTW = $clog2(DEPTH + 1);

    logic [1:0]      sync_q;
    logic            frame_done, busy, nonempty, full, half, pop, ovr, tmo_hit;
    rx_word_t        new_word, head;
    logic [CNTW-1:0] count;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= 2'b11;
        else     sync_q <= {sync_q[0], cfg_loop ? txd_loop : rxd_pin};
    end

    srx_sampler #(.OSR(OSR)) u_samp (
        .clk(clk), .rst(rst), .tick(tick16), .en(cfg_rx_en), .line(sync_q[1]),
        .mode(cfg_mode), .odd(cfg_odd), .done(frame_done), .word(new_word), .busy(busy)
    );

    srx_fifo #(.DEPTH(DEPTH), .W(10)) u_fifo (
        .clk(clk), .rst(rst), .flush(rx_flush), .push(frame_done), .din(new_word),
        .pop(pop), .dout(head), .count(count)
    );

    assign nonempty = (count != '0);
    assign full     = (count == CNTW'(DEPTH));
    assign half     = (count >= CNTW'(DEPTH / 2));
    assign pop      = rd_en && nonempty;

    always_ff @(posedge clk) begin
        if (rst || rx_flush)         ovr <= 1'b0;
        else if (frame_done && full) ovr <= 1'b1;
        else if (pop)                ovr <= 1'b0;
    end

    srx_idle_timer #(.OSR(OSR), .CHAR_BITS(10)) u_tmr (
        .clk(clk), .rst(rst), .tick(tick16),
        .clr(frame_done || pop || rx_flush || !nonempty),
        .run(!busy), .limit(cfg_tmo), .expired(tmo_hit)
    );

    always_comb begin
        status        = '0;
        status[ST_NE] = nonempty;
        status[ST_PE] = nonempty && head.hi && cfg_mode[1];
        status[ST_FE] = nonempty && head.fe;
        status[ST_OV] = ovr;
        status[ST_TO] = tmo_hit && nonempty;
        status[ST_HF] = half;
    end

    assign rd_data = head;
    assign irq     = |(status & cfg_irq_en);
endmodule

// File: rtl/srx_core_chk.sv
module srx_core_chk (
    input logic       clk,
    input logic       rst,
    input logic       rx_flush,
    input logic       rd_en,
    input logic       cfg_rx_en,
    input logic [2:0] cfg_mode,
    input logic       frame_done,
    input logic [8:0] status
);
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        rx_flush |=> !status[0]); // R11
    AST_OVR_CLEARS_ON_READ: assert property (@(posedge clk) disable iff (rst)
        (rd_en && status[0] && !frame_done && !rx_flush) |=> !status[5]); // R6
    AST_HALF_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
        status[8] |-> status[0]); // R5
    AST_DONE_FILLS: assert property (@(posedge clk) disable iff (rst)
        (frame_done && !rx_flush) |=> status[0]); // R5
    AST_TIMEOUT_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
        status[7] |-> status[0]); // R7
    AST_PE_PARITY_ONLY: assert property (@(posedge clk) disable iff (rst)
        status[3] |-> cfg_mode[1]); // R2
    AST_OFF_NO_FRAME: assert property (@(posedge clk) disable iff (rst)
        !cfg_rx_en |=> !frame_done); // R10
endmodule

bind srx_core srx_core_chk u_chk (
    .clk(clk), .rst(rst), .rx_flush(rx_flush), .rd_en(rd_en), .cfg_rx_en(cfg_rx_en),
    .cfg_mode(cfg_mode), .frame_done(frame_done), .status(status)
);

// File: tb/srx_core_bench.sv
module srx_core_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser = 1'b1;
    logic       to_pin = 1'b1;
    logic       cfg_loop = 1'b0, cfg_rx_en = 1'b1, cfg_odd = 1'b0;
    logic [2:0] cfg_mode = 3'b001;
    logic [7:0] cfg_tmo = 8'd0;
    logic [8:0] cfg_irq_en = 9'd0;
    logic       rx_flush = 1'b0, rd_en = 1'b0;
    logic [9:0] rd_data;
    logic [8:0] status;
    logic       irq;
    int         total = 0, bad = 0;
    bit         ended = 1'b0;

    always #2 clk = ~clk;

    srx_core u_srx_core (
        .clk(clk), .rst(rst), .tick16(1'b1),
        .rxd_pin(to_pin ? ser : 1'b1), .txd_loop(to_pin ? 1'b1 : ser),
        .cfg_loop(cfg_loop), .cfg_rx_en(cfg_rx_en), .cfg_mode(cfg_mode), .cfg_odd(cfg_odd),
        .cfg_tmo(cfg_tmo), .cfg_irq_en(cfg_irq_en), .rx_flush(rx_flush), .rd_en(rd_en),
        .rd_data(rd_data), .status(status), .irq(irq)
    );

    // mode, odd, bad parity, stop level, data, expected word
    localparam logic [24:0] VEC [8] = '{
        {3'b001, 1'b0, 1'b0, 1'b1, 9'h0A5, 10'h0A5},
        {3'b111, 1'b0, 1'b0, 1'b1, 9'h03C, 10'h03C},
        {3'b111, 1'b1, 1'b1, 1'b1, 9'h081, 10'h181},
        {3'b011, 1'b0, 1'b0, 1'b1, 9'h055, 10'h055},
        {3'b011, 1'b1, 1'b1, 1'b1, 9'h07F, 10'h17F},
        {3'b100, 1'b0, 1'b0, 1'b1, 9'h1C3, 10'h1C3},
        {3'b101, 1'b0, 1'b0, 1'b1, 9'h0F0, 10'h0F0},
        {3'b001, 1'b0, 1'b0, 1'b0, 9'h05A, 10'h25A}
    };

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive_bit(input logic b);
        ser = b;
        repeat (16) @(negedge clk);
    endtask

    task automatic send(input logic [2:0] m, input logic od, input logic pbad,
                        input logic stp, input logic [8:0] d);
        int n;
        logic [8:0] bits;
        n = (m == 3'b100 || m == 3'b101 || m == 3'b111) ? 9 : 8;
        case (m)
            3'b011:  bits = {1'b0, (^d[6:0]) ^ od ^ pbad, d[6:0]};
            3'b111:  bits = {(^d[7:0]) ^ od ^ pbad, d[7:0]};
            3'b100, 3'b101: bits = d;
            default: bits = {1'b0, d[7:0]};
        endcase
        drive_bit(1'b0);
        for (int i = 0; i < n; i++) drive_bit(bits[i]);
        drive_bit(stp);
        drive_bit(1'b1);
    endtask

    task automatic pop_one();
        @(negedge clk) rd_en = 1'b1;
        @(negedge clk) rd_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            total++; bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(status == 9'd0, "R5 reset status", status, 0);
        chk(irq == 1'b0, "R8 reset irq", irq, 0);

        // R1 R2 R3 R12 format table
        foreach (VEC[k]) begin
            cfg_mode = VEC[k][24:22];
            cfg_odd  = VEC[k][21];
            send(VEC[k][24:22], VEC[k][21], VEC[k][20], VEC[k][19], VEC[k][18:10]);
            chk(rd_data == VEC[k][9:0], "R1 word", rd_data, VEC[k][9:0]);
            chk(status[3] == (VEC[k][8] && VEC[k][23]), "R12 status pe", status[3], VEC[k][8] && VEC[k][23]);
            chk(status[4] == VEC[k][9], "R12 status fe", status[4], VEC[k][9]);
            pop_one();
            chk(status[0] == 1'b0, "R5 empty after pop", status[0], 0);
        end
        cfg_mode = 3'b001; cfg_odd = 1'b0;

        // R3 break
        ser = 1'b0; repeat (160) @(negedge clk);
        ser = 1'b1; repeat (32) @(negedge clk);
        chk(rd_data == 10'h200 && status[0], "R3 break word", rd_data, 10'h200);
        pop_one();

        // R4 short glitch
        ser = 1'b0; repeat (5) @(negedge clk);
        ser = 1'b1; repeat (200) @(negedge clk);
        chk(status[0] == 1'b0, "R4 glitch ignored", status[0], 0);

        // R5 R6 fill, order, overrun
        for (int i = 0; i < 7; i++) send(3'b001, 1'b0, 1'b0, 1'b1, 9'(8'h10 + i));
        chk(status[8] == 1'b0, "R5 seven not half", status[8], 0);
        send(3'b001, 1'b0, 1'b0, 1'b1, 9'h17);
        chk(status[8] == 1'b1, "R5 eight half", status[8], 1);
        for (int i = 8; i < 16; i++) send(3'b001, 1'b0, 1'b0, 1'b1, 9'(8'h10 + i));
        chk(status[5] == 1'b0, "R6 full no overrun", status[5], 0);
        send(3'b001, 1'b0, 1'b0, 1'b1, 9'h0EE);
        chk(status[5] == 1'b1, "R6 overrun set", status[5], 1);
        cfg_irq_en = 9'h020;
        @(negedge clk);
        chk(irq == 1'b1, "R8 irq on overrun", irq, 1);
        chk(rd_data == 10'h010, "R5 head oldest", rd_data, 10'h010);
        pop_one();
        chk(status[5] == 1'b0, "R6 overrun cleared", status[5], 0);
        chk(irq == 1'b0, "R8 irq drops", irq, 0);
        chk(rd_data == 10'h011, "R5 second in order", rd_data, 10'h011);
        @(negedge clk) rx_flush = 1'b1;
        @(negedge clk) rx_flush = 1'b0;
        chk(status == 9'd0, "R11 flush empties", status, 0);

        // R7 timeout
        cfg_tmo = 8'd2;
        send(3'b001, 1'b0, 1'b0, 1'b1, 9'h033);
        repeat (250) @(negedge clk);
        chk(status[7] == 1'b0, "R7 not yet", status[7], 0);
        repeat (80) @(negedge clk);
        chk(status[7] == 1'b1, "R7 timeout set", status[7], 1);
        cfg_irq_en = 9'h080;
        @(negedge clk);
        chk(irq == 1'b1, "R8 irq timeout", irq, 1);
        cfg_irq_en = 9'h000;
        @(negedge clk);
        chk(irq == 1'b0, "R8 masked", irq, 0);
        pop_one();
        chk(status[7] == 1'b0, "R7 cleared by read", status[7], 0);
        cfg_tmo = 8'd0;

        // R9 loopback
        cfg_loop = 1'b1;
        send(3'b001, 1'b0, 1'b0, 1'b1, 9'h0C4);
        chk(status[0] == 1'b0, "R9 pin ignored", status[0], 0);
        to_pin = 1'b0;
        send(3'b001, 1'b0, 1'b0, 1'b1, 9'h0C4);
        chk(rd_data == 10'h0C4 && status[0], "R9 loop word", rd_data, 10'h0C4);
        pop_one();
        cfg_loop = 1'b0; to_pin = 1'b1;

        // R10 disabled
        cfg_rx_en = 1'b0;
        send(3'b001, 1'b0, 1'b0, 1'b1, 9'h099);
        chk(status[0] == 1'b0, "R10 disabled", status[0], 0);
        cfg_rx_en = 1'b1;
        send(3'b001, 1'b0, 1'b0, 1'b1, 9'h099);
        chk(rd_data == 10'h099, "R10 re-enabled", rd_data, 10'h099);

        ended = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule